// File: doc/BRIEF.md
# Saturating PI Speed Controller

This block closes a motor speed loop. A tick strobe arrives at a fixed control interval, nominally 1 ms. On each tick the block forms the speed error, which is the setpoint minus the measured speed, as a signed value. It multiplies the error by an unsigned fixed-point proportional gain in one unit. A second, separate unit keeps a rectangular running sum of the error scaled by the integral gain. The two terms are added, rounded back to integer duty units, clamped to the range 0 to `PWM_MAX` and stored as the duty command.

The integrator stops accumulating while the output sits at a limit and the error would push it further into that limit. This keeps the integral term from winding up. A thin counter-compare PWM stage turns the registered duty into a pulse train. It takes a new duty value only at a period boundary, so no pulse is ever cut short or lengthened part-way through a period. Setting the integral gain to zero leaves a pure proportional controller and changes nothing else.

Top module: `pi_speed_ctrl`

## Requirements
- R1: On a tick, with e = setpoint - measured (signed) and gains holding FRAC fractional bits, the new duty is floor((Kp*e + I + 2^(FRAC-1)) / 2^FRAC), where I is the integral accumulator value before the tick. The result is clamped to 0 when it is at or below zero and to PWM_MAX when it is at or above PWM_MAX.
- R2: duty_o changes only in the cycle that follows a cycle with tick_i high. It holds its value at every other edge.
- R3: On a tick where integration is allowed, the accumulator becomes I + Ki*e. This is a rectangular sum with one term per tick, and it first affects the duty on the following tick.
- R4: The accumulator is clamped to the range INT_MIN to INT_MAX, both inclusive.
- R5: Accumulation is skipped on any tick where the unclamped rounded output is at or above PWM_MAX and e > 0. It is also skipped when that output is at or below 0 and e < 0.
- R6: With Ki = 0 the accumulator never changes, and the duty equals the clamped, rounded Kp*e term.
- R7: The PWM counter runs 0 to PWM_MAX-1 and wraps. The compare value is reloaded from duty_o at the edge where the counter leaves PWM_MAX-1. pwm_o is registered, and after any edge it is high exactly when the new count is below the new compare value. A duty of D therefore gives D high cycles per PWM_MAX-cycle period.
- R8: Synchronous active-high reset clears the accumulator, duty_o, the PWM counter and the compare value, and drives pwm_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle control-interval strobe |
| setpoint_i | input | DW | Signed speed setpoint |
| measured_i | input | DW | Signed measured speed |
| kp_i | input | GW | Unsigned proportional gain, FRAC fractional bits |
| ki_i | input | GW | Unsigned integral gain, FRAC fractional bits |
| duty_o | output | DUTY_W | Registered duty command, 0..PWM_MAX |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with DW=10, GW=8, FRAC=4, DUTY_W=6, PWM_MAX=50, INT_MAX=640 and INT_MIN=-320, and it issues a tick every 60 cycles. A gain of 16 is unity, so the rounding midpoints can be worked out by hand. A period of only 50 cycles lets whole PWM periods be counted. The integral ceiling sits below the output ceiling, so the accumulator clamp can be reached with the proportional gain at zero. Hard saturation followed by a zero error then shows directly whether the integrator wound up.

// File: rtl/pi_pkg.sv
package pi_pkg;

    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_LOW  = 2'd1,
        SAT_HIGH = 2'd2
    } sat_e;

    typedef struct packed {
        logic neg;
        logic zero;
    } err_sign_t;

    // Integration is refused when the error pushes the output deeper into a limit.
    function automatic logic integ_allowed(sat_e s, err_sign_t es);
        logic push_up;
        logic push_dn;
        push_up = (s == SAT_HIGH) && !es.neg && !es.zero;
        push_dn = (s == SAT_LOW) && es.neg;
        return !(push_up || push_dn);
    endfunction

endpackage

// File: rtl/pi_prop_unit.sv
module pi_prop_unit #(
    parameter int EW = 13,
    parameter int GW = 10,
    localparam int PW = EW + GW + 1
) (
    input  logic signed [EW-1:0] err_i,
    input  logic        [GW-1:0] kp_i,
    output logic signed [PW-1:0] p_o
);
    logic signed [PW-1:0] err_x;
    logic signed [PW-1:0] kp_x;

    always_comb begin
        err_x = PW'(err_i);
        kp_x  = $signed(PW'({1'b0, kp_i}));
        p_o   = err_x * kp_x;
    end
endmodule

// File: rtl/pi_integ_unit.sv
module pi_integ_unit #(
    parameter int EW      = 13,
    parameter int GW      = 10,
    parameter int AW      = 28,
    parameter int INT_MIN = -64000,
    parameter int INT_MAX = 64000,
    localparam int PW = EW + GW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 hold_i,
    input  logic signed [EW-1:0] err_i,
    input  logic        [GW-1:0] ki_i,
    output logic signed [AW-1:0] acc_o
);
    localparam logic signed [AW:0] LIM_HI = (AW+1)'(INT_MAX);
    localparam logic signed [AW:0] LIM_LO = (AW+1)'(INT_MIN);

    logic signed [PW-1:0] err_x;
    logic signed [PW-1:0] ki_x;
    logic signed [PW-1:0] step;
    logic signed [AW:0]   sum_w;
    logic signed [AW:0]   sum_c;
    logic signed [AW-1:0] acc_q;

    always_comb begin
        err_x = PW'(err_i);
        ki_x  = $signed(PW'({1'b0, ki_i}));
        step  = err_x * ki_x;
        sum_w = (AW+1)'(acc_q) + (AW+1)'(step);
        if (sum_w > LIM_HI)      sum_c = LIM_HI;
        else if (sum_w < LIM_LO) sum_c = LIM_LO;
        else                     sum_c = sum_w;
    end

    always_ff @(posedge clk) begin
        if (rst)                   acc_q <= '0;
        else if (tick_i && !hold_i) acc_q <= AW'(sum_c);
    end

    assign acc_o = acc_q;

    // R4
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
        ((AW+1)'(acc_q) <= LIM_HI) && ((AW+1)'(acc_q) >= LIM_LO));
    // R5
    windup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && hold_i) |=> $stable(acc_q));
    // R6
    zero_ki_chk: assert property (@(posedge clk) disable iff (rst)
        (ki_i == '0) |=> $stable(acc_q));
endmodule

// File: rtl/pi_pwm_stage.sv
module pi_pwm_stage #(
    parameter int DUTY_W  = 10,
    parameter int PWM_MAX = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);
    localparam logic [DUTY_W-1:0] LAST = DUTY_W'(PWM_MAX - 1);

    logic [DUTY_W-1:0] cnt_q, cnt_n;
    logic [DUTY_W-1:0] cmp_q, cmp_n;
    logic              pwm_q;

    always_comb begin
        if (cnt_q == LAST) begin
            cnt_n = '0;
            cmp_n = duty_i;
        end else begin
            cnt_n = cnt_q + 1'b1;
            cmp_n = cmp_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cmp_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            cmp_q <= cmp_n;
            pwm_q <= (cnt_n < cmp_n);
        end
    end

    assign pwm_o = pwm_q;

    // R7
    cmp_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> $stable(cmp_q));
    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/pi_speed_ctrl.sv
module pi_speed_ctrl
    import pi_pkg::*;
#(
    parameter int DW      = 12,
    parameter int GW      = 10,
    parameter int FRAC    = 6,
    parameter int DUTY_W  = 10,
    parameter int PWM_MAX = 1000,
    parameter int ACC_W   = DW + GW + 6,
    parameter int INT_MAX = 64000,
    parameter int INT_MIN = -64000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic signed [DW-1:0] setpoint_i,
    input  logic signed [DW-1:0] measured_i,
    input  logic        [GW-1:0] kp_i,
    input  logic        [GW-1:0] ki_i,
    output logic        [DUTY_W-1:0] duty_o,
    output logic                 pwm_o
);
    localparam int EW = DW + 1;
    localparam int PW = EW + GW + 1;
    localparam int SW = ACC_W + 1;
    localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);
    localparam logic signed [SW-1:0] TOP  = SW'(PWM_MAX);

    logic signed [EW-1:0]    err;
    err_sign_t               esign;
    logic signed [PW-1:0]    p_term;
    logic signed [ACC_W-1:0] i_term;
    logic signed [SW-1:0]    total;
    logic signed [SW-1:0]    rounded;
    sat_e                    sat;
    logic                    hold;
    logic [DUTY_W-1:0]       duty_n;
    logic [DUTY_W-1:0]       duty_q;

    always_comb begin
        err        = EW'(setpoint_i) - EW'(measured_i);
        esign.neg  = err[EW-1];
        esign.zero = (err == '0);
    end

    pi_prop_unit #(.EW(EW), .GW(GW)) u_prop (
        .err_i (err),
        .kp_i  (kp_i),
        .p_o   (p_term)
    );

    pi_integ_unit #(
        .EW(EW), .GW(GW), .AW(ACC_W), .INT_MIN(INT_MIN), .INT_MAX(INT_MAX)
    ) u_integ (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .hold_i (hold),
        .err_i  (err),
        .ki_i   (ki_i),
        .acc_o  (i_term)
    );

    always_comb begin
        total   = SW'(p_term) + SW'(i_term);
        rounded = (total + HALF) >>> FRAC;
        if (rounded >= TOP)                       sat = SAT_HIGH;
        else if (rounded[SW-1] || rounded == '0)  sat = SAT_LOW;
        else                                      sat = SAT_NONE;
        hold = !integ_allowed(sat, esign);
        case (sat)
            SAT_HIGH: duty_n = DUTY_W'(PWM_MAX);
            SAT_LOW:  duty_n = '0;
            default:  duty_n = DUTY_W'(rounded);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         duty_q <= '0;
        else if (tick_i) duty_q <= duty_n;
    end

    assign duty_o = duty_q;

    pi_pwm_stage #(.DUTY_W(DUTY_W), .PWM_MAX(PWM_MAX)) u_pwm (
        .clk    (clk),
        .rst    (rst),
        .duty_i (duty_q),
        .pwm_o  (pwm_o)
    );

    // R1
    duty_cap_chk: assert property (@(posedge clk) disable iff (rst)
        duty_q <= DUTY_W'(PWM_MAX));
    // R2
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(duty_q));
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (duty_q == '0 && !pwm_o));
endmodule

// File: tb/tb_pi_speed_ctrl.sv
module tb_pi_speed_ctrl;
    localparam int DW = 10, GW = 8, FRAC = 4, DUTY_W = 6, PWM_MAX = 50;
    localparam int INT_MAX = 640, INT_MIN = -320, GAP = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic signed [DW-1:0] sp = '0, meas = '0;
    logic [GW-1:0] kp = '0, ki = '0;
    logic [DUTY_W-1:0] duty;
    logic pwm;

    int checks = 0, errors = 0;
    bit done = 0;
    string tag = "R8";

    always #2.5 clk = ~clk;

    pi_speed_ctrl #(
        .DW(DW), .GW(GW), .FRAC(FRAC), .DUTY_W(DUTY_W), .PWM_MAX(PWM_MAX),
        .INT_MAX(INT_MAX), .INT_MIN(INT_MIN)
    ) dut (
        .clk(clk), .rst(rst), .tick_i(tick), .setpoint_i(sp), .measured_i(meas),
        .kp_i(kp), .ki_i(ki), .duty_o(duty), .pwm_o(pwm)
    );

    // behavioural reference
    longint m_acc = 0, m_duty = 0, m_cnt = 0, m_cmp = 0;
    bit m_pwm = 0;

    always @(posedge clk) begin
        longint e, s, r, nd;
        bit skip;
        if (rst) begin
            m_acc = 0; m_duty = 0; m_cnt = 0; m_cmp = 0; m_pwm = 0;
        end else begin
            if (m_cnt == PWM_MAX - 1) begin m_cnt = 0; m_cmp = m_duty; end
            else m_cnt = m_cnt + 1;
            m_pwm = (m_cnt < m_cmp);
            if (tick) begin
                e = longint'(sp) - longint'(meas);
                s = longint'(kp) * e + m_acc;
                r = (s + (1 << (FRAC - 1))) >>> FRAC;
                nd = (r >= PWM_MAX) ? PWM_MAX : ((r <= 0) ? 0 : r);
                skip = (r >= PWM_MAX && e > 0) || (r <= 0 && e < 0);
                if (!skip) begin
                    m_acc = m_acc + longint'(ki) * e;
                    if (m_acc > INT_MAX) m_acc = INT_MAX;
                    if (m_acc < INT_MIN) m_acc = INT_MIN;
                end
                m_duty = nd;
            end
        end
    end

    task automatic check(string req, longint act, longint exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check(tag, longint'(duty), m_duty, "duty");
        check("R7", longint'(pwm), longint'(m_pwm), "pwm");
    endtask

    task automatic tick_wait(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
            repeat (GAP - 1) step();
        end
    endtask

    task automatic pulse_reset();
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
    endtask

    initial begin
        int highs;
        // R8: reset state
        tag = "R8";
        repeat (3) step();
        check("R8", longint'(duty), 0, "duty in reset");
        check("R8", longint'(pwm), 0, "pwm in reset");
        rst = 1'b0;

        // R6: proportional only, unity gain, e=30 -> duty 30
        tag = "R6";
        kp = 8'd16; ki = 8'd0; sp = 10'sd30; meas = 10'sd0;
        tick_wait(3);
        check("R6", longint'(duty), 30, "pure P duty");

        // R7: one full period with compare 30 -> 30 high cycles
        highs = 0;
        for (int i = 0; i < PWM_MAX; i++) begin step(); if (pwm) highs++; end
        check("R7", highs, 30, "high cycles per period");

        // R2: duty holds between ticks
        tag = "R2";
        sp = 10'sd5;
        repeat (20) step();
        check("R2", longint'(duty), 30, "held without tick");

        // R1: low clamp and round-half-up
        tag = "R1";
        kp = 8'd24; sp = 10'sd0; meas = 10'sd10;
        tick_wait(1);
        check("R1", longint'(duty), 0, "negative clamps to 0");
        sp = 10'sd15; meas = 10'sd4;   // 24*11 = 264 -> 16.5 -> 17
        tick_wait(1);
        check("R1", longint'(duty), 17, "round half up");

        // R3: integral only, Ki=4, e=10
        pulse_reset();
        tag = "R3";
        kp = 8'd0; ki = 8'd4; sp = 10'sd10; meas = 10'sd0;
        tick_wait(1);
        check("R3", longint'(duty), 0, "first tick uses old accumulator");
        tick_wait(2);
        check("R3", longint'(duty), 5, "accumulated 80/16 rounded");

        // R4: accumulator ceiling 640 -> duty 40
        tag = "R4";
        ki = 8'd16;
        tick_wait(10);
        check("R4", longint'(duty), 40, "integral clamped");

        // R5: hard saturation must not wind up
        pulse_reset();
        tag = "R5";
        kp = 8'd16; ki = 8'd16; sp = 10'sd200; meas = 10'sd0;
        tick_wait(8);
        check("R5", longint'(duty), PWM_MAX, "saturated high");
        highs = 0;
        for (int i = 0; i < PWM_MAX; i++) begin step(); if (pwm) highs++; end
        check("R7", highs, PWM_MAX, "full duty period");
        meas = 10'sd200;
        tick_wait(1);
        check("R5", longint'(duty), 0, "no wound-up integral");

        // R8: mid-run reset
        kp = 8'd16; ki = 8'd0; sp = 10'sd40; meas = 10'sd0;
        tick_wait(2);
        tag = "R8";
        rst = 1'b1;
        step();
        step();
        check("R8", longint'(duty), 0, "duty after reset");
        check("R8", longint'(pwm), 0, "pwm after reset");
        rst = 1'b0;

        // R1: mixed stimulus against the reference
        tag = "R1";
        for (int t = 0; t < 120; t++) begin
            sp   = DW'($signed(int'($urandom_range(0, 400)) - 200));
            meas = DW'($signed(int'($urandom_range(0, 400)) - 200));
            kp   = GW'($urandom_range(0, 63));
            ki   = GW'($urandom_range(0, 31));
            tick_wait(1);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule